// File: doc/BRIEF.md
# Preload Hint Address Generator

This block forms the target address of a cache preload hint from operands that a decoder has already pulled apart. A request carries a base value, an offset, an add/subtract flag, a format select and a preload kind. The offset is either an unsigned immediate magnitude or a register value passed through a barrel shifter. The block adds the offset to the base or subtracts it, wrapping modulo 2^32, and applies no alignment check. One cycle later it presents the address, the reported kind and a verdict on whether the operands were legal.

There are two formats. The wide format accepts a broad set of shifts and immediates up to 4095 in either direction. The compact format restricts negative immediates, allows only add with a short left shift on register offsets, and forbids some base registers. Any violation raises the illegal flag and withholds the request, so the hint completes with no memory effect. A write-intent preload is passed on only when multiprocessing support is enabled. Otherwise it is reported as a plain data preload.

Top module: `preload_addr_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid`, `out_req` and `out_illegal`.
- R2: With an immediate offset (`in_use_reg`=0), `out_addr` is `in_base` plus `in_imm`, or minus it when `in_sub`=1, wrapped modulo 2^32. An unaligned result is still reported as a legal request.
- R3: In the wide format (`in_wide`=1), an immediate magnitude above 4095 is illegal in either direction.
- R4: In the compact format, a subtracted immediate above 255 is illegal unless the base register index is 15, the program counter. With base index 15 the limit is 4095. An added immediate may reach 4095.
- R5: In the wide format, a register offset is shifted by `in_shift_amt` according to `in_shift_type`: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. For logical right and arithmetic right, an amount of 0 means 32, giving zero or a full sign fill. A rotate by 0 is illegal. The shifted value may be added or subtracted.
- R6: In the compact format, a register offset is legal only if all of these hold: it is added, the shift is logical left by 0 to 3, and the base index is neither 15 nor 13 (the stack pointer).
- R7: A register offset whose index `in_off_idx` is 15 is illegal in both formats.
- R8: `in_kind` uses 00 for data read, 01 for data with write intent, 10 for instruction; 11 is illegal. Kind 01 is reported as 00 when `in_mp_en` is low.
- R9: For an illegal request, `out_illegal` is high and `out_req` is low. For a legal one, `out_req` is high and `out_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_wide | input | 1 | 1 = wide format, 0 = compact format |
| in_kind | input | 2 | Preload kind |
| in_mp_en | input | 1 | Multiprocessing support enable |
| in_base | input | 32 | Base register value |
| in_base_idx | input | 4 | Base register index |
| in_use_reg | input | 1 | 1 = register offset, 0 = immediate |
| in_sub | input | 1 | 1 = subtract offset |
| in_imm | input | 13 | Immediate offset magnitude |
| in_off | input | 32 | Offset register value |
| in_off_idx | input | 4 | Offset register index |
| in_shift_type | input | 2 | Shift kind for register offset |
| in_shift_amt | input | 5 | Shift amount |
| out_valid | output | 1 | Result present |
| out_req | output | 1 | Legal preload request |
| out_illegal | output | 1 | Operand violation |
| out_addr | output | 32 | Computed address |
| out_kind | output | 2 | Reported preload kind |

## Verification
A single request can hit the kind downgrade and an operand violation in the same cycle. An example is a write-intent preload with `in_mp_en` low that also subtracts a register in the compact format. The bench issues exactly this combination and expects the illegal flag, no request, and a kind already reported as 00, so neither path can mask the other. Two requests are also sent on back-to-back cycles, one legal and one illegal, followed by an idle cycle. This shows that a verdict never carries over into the next result.

// File: rtl/preload_addr_gen.sv
module preload_addr_gen #(
  parameter int AW              = 32,
  parameter int IMM_W           = 13,
  parameter int RIDX_W          = 4,
  parameter int SAMT_W          = 5,
  parameter int PC_IDX          = 15,
  parameter int SP_IDX          = 13,
  parameter int WIDE_IMM_MAX    = 4095,
  parameter int COMPACT_NEG_MAX = 255,
  parameter int COMPACT_LSL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [1:0]        in_kind,
  input  logic              in_mp_en,
  input  logic [AW-1:0]     in_base,
  input  logic [RIDX_W-1:0] in_base_idx,
  input  logic              in_use_reg,
  input  logic              in_sub,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [AW-1:0]     in_off,
  input  logic [RIDX_W-1:0] in_off_idx,
  input  logic [1:0]        in_shift_type,
  input  logic [SAMT_W-1:0] in_shift_amt,
  output logic              out_valid,
  output logic              out_req,
  output logic              out_illegal,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_kind
);

  localparam logic [1:0] SH_LSL = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ASR = 2'b10;
  localparam logic [1:0] SH_ROR = 2'b11;
  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_BAD   = 2'b11;
  localparam logic [RIDX_W-1:0] PC_R = RIDX_W'(PC_IDX);
  localparam logic [RIDX_W-1:0] SP_R = RIDX_W'(SP_IDX);
  localparam logic [IMM_W-1:0] LIM_FULL = IMM_W'(WIDE_IMM_MAX);
  localparam logic [IMM_W-1:0] LIM_NEG  = IMM_W'(COMPACT_NEG_MAX);
  localparam logic [SAMT_W-1:0] LSL_MAX = SAMT_W'(COMPACT_LSL_MAX);

  logic [AW-1:0]    shifted;
  logic [AW-1:0]    offset;
  logic [AW-1:0]    addr;
  logic [IMM_W-1:0] imm_lim;
  logic             imm_bad;
  logic             reg_bad;
  logic             wide_bad;
  logic             compact_bad;
  logic             bad;
  logic [1:0]       kind_rep;
  logic             amt_zero;

  assign amt_zero = (in_shift_amt == '0);

  always_comb begin
    case (in_shift_type)
      SH_LSL:  shifted = in_off << in_shift_amt;
      SH_LSR:  shifted = amt_zero ? '0 : (in_off >> in_shift_amt);
      SH_ASR:  shifted = amt_zero ? {AW{in_off[AW-1]}}
                                  : AW'($signed(in_off) >>> in_shift_amt);
      default: shifted = (in_off >> in_shift_amt) | (in_off << (AW - int'(in_shift_amt)));
    endcase
  end

  assign offset = in_use_reg ? shifted : {{(AW-IMM_W){1'b0}}, in_imm};
  assign addr   = in_sub ? (in_base - offset) : (in_base + offset);

  assign imm_lim = (!in_wide && in_sub && in_base_idx != PC_R) ? LIM_NEG : LIM_FULL;
  assign imm_bad = !in_use_reg && (in_imm > imm_lim);

  assign wide_bad    = (in_shift_type == SH_ROR) && amt_zero;
  assign compact_bad = in_sub || in_base_idx == PC_R || in_base_idx == SP_R ||
                       in_shift_type != SH_LSL || in_shift_amt > LSL_MAX;
  assign reg_bad     = in_use_reg &&
                       (in_off_idx == PC_R || (in_wide ? wide_bad : compact_bad));

  assign bad      = imm_bad || reg_bad || in_kind == K_BAD;
  assign kind_rep = (in_kind == K_WRITE && !in_mp_en) ? K_READ : in_kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_addr    <= '0;
      out_kind    <= K_READ;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && bad;
      if (in_valid) begin
        out_addr <= addr;
        out_kind <= kind_rep;
      end
    end
  end

  assign out_req = out_valid && !out_illegal;

endmodule

// File: rtl/preload_addr_gen_checker.sv
module preload_addr_gen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_wide,
  input logic [1:0]  in_kind,
  input logic        in_mp_en,
  input logic [31:0] in_base,
  input logic        in_use_reg,
  input logic        in_sub,
  input logic [12:0] in_imm,
  input logic [3:0]  in_off_idx,
  input logic        out_valid,
  input logic        out_req,
  input logic        out_illegal,
  input logic [31:0] out_addr,
  input logic [1:0]  out_kind
);

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_req && !out_illegal);

  assert_zero_imm_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_use_reg && in_imm == 13'd0 |=> out_addr == $past(in_base));

  assert_compact_no_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_wide && in_use_reg && in_sub |=> out_illegal && !out_req);

  assert_no_pc_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_use_reg && in_off_idx == 4'd15 |=> out_illegal && !out_req);

  assert_downgrade_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == 2'b01 && !in_mp_en |=> out_kind == 2'b00);

  assert_bad_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == 2'b11 |=> out_illegal && !out_req);

endmodule

bind preload_addr_gen preload_addr_gen_checker u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
  .in_kind(in_kind), .in_mp_en(in_mp_en), .in_base(in_base),
  .in_use_reg(in_use_reg), .in_sub(in_sub), .in_imm(in_imm),
  .in_off_idx(in_off_idx), .out_valid(out_valid), .out_req(out_req),
  .out_illegal(out_illegal), .out_addr(out_addr), .out_kind(out_kind)
);

// File: tb/preload_addr_gen_bench.sv
module preload_addr_gen_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_wide, in_mp_en, in_use_reg, in_sub;
  logic [1:0]  in_kind, in_shift_type;
  logic [31:0] in_base, in_off;
  logic [3:0]  in_base_idx, in_off_idx;
  logic [12:0] in_imm;
  logic [4:0]  in_shift_amt;
  logic out_valid, out_req, out_illegal;
  logic [31:0] out_addr;
  logic [1:0]  out_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  preload_addr_gen u_preload_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .in_kind(in_kind), .in_mp_en(in_mp_en), .in_base(in_base),
    .in_base_idx(in_base_idx), .in_use_reg(in_use_reg), .in_sub(in_sub),
    .in_imm(in_imm), .in_off(in_off), .in_off_idx(in_off_idx),
    .in_shift_type(in_shift_type), .in_shift_amt(in_shift_amt),
    .out_valid(out_valid), .out_req(out_req), .out_illegal(out_illegal),
    .out_addr(out_addr), .out_kind(out_kind)
  );

  task automatic dflt();
    in_valid = 0; in_wide = 1; in_kind = 2'b00; in_mp_en = 1;
    in_base = 32'h0; in_base_idx = 4'd2; in_use_reg = 0; in_sub = 0;
    in_imm = 13'd0; in_off = 32'h0; in_off_idx = 4'd3;
    in_shift_type = 2'b00; in_shift_amt = 5'd0;
  endtask

  task automatic fire();
    in_valid = 1;
    @(negedge clk);
  endtask

  task automatic expect_out(string tag, bit req, logic [31:0] addr, logic [1:0] kind);
    checks++;
    if (out_valid !== 1'b1 || out_req !== req || out_illegal !== !req ||
        out_kind !== kind || (req && out_addr !== addr)) begin
      fails++;
      $display("FAIL %s: valid=%b req=%b ill=%b addr=%h kind=%b, expected valid=1 req=%b ill=%b addr=%h kind=%b",
               tag, out_valid, out_req, out_illegal, out_addr, out_kind, req, !req, addr, kind);
    end
  endtask

  task automatic expect_idle(string tag);
    checks++;
    if (out_valid !== 0 || out_req !== 0 || out_illegal !== 0) begin
      fails++;
      $display("FAIL %s: valid=%b req=%b ill=%b, expected all 0", tag, out_valid, out_req, out_illegal);
    end
  endtask

  task automatic t_reset();
    dflt(); rst_n = 0;
    repeat (3) @(negedge clk);
    expect_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
    expect_idle("R1 idle after reset");
  endtask

  task automatic t_imm_addr();
    dflt(); in_base = 32'h1000; in_imm = 13'h123; fire(); expect_out("R2 add", 1, 32'h1123, 2'b00);
    dflt(); in_base = 32'h10; in_imm = 13'h20; in_sub = 1; fire(); expect_out("R2 wrap below zero", 1, 32'hFFFF_FFF0, 2'b00);
    dflt(); in_base = 32'hFFFF_FFFF; in_imm = 13'd2; fire(); expect_out("R2 wrap above top", 1, 32'h1, 2'b00);
    dflt(); in_base = 32'h1000; in_imm = 13'd3; fire(); expect_out("R2 unaligned", 1, 32'h1003, 2'b00);
  endtask

  task automatic t_wide_imm();
    dflt(); in_base = 32'h2000; in_imm = 13'd4095; in_sub = 1; fire(); expect_out("R3 -4095 ok", 1, 32'h1001, 2'b00);
    dflt(); in_imm = 13'd4096; fire(); expect_out("R3 +4096 bad", 0, 32'h0, 2'b00);
    dflt(); in_imm = 13'd4096; in_sub = 1; fire(); expect_out("R3 -4096 bad", 0, 32'h0, 2'b00);
  endtask

  task automatic t_compact_imm();
    dflt(); in_wide = 0; in_base = 32'h1000; in_imm = 13'd255; in_sub = 1; fire(); expect_out("R4 -255 ok", 1, 32'hF01, 2'b00);
    dflt(); in_wide = 0; in_imm = 13'd256; in_sub = 1; fire(); expect_out("R4 -256 bad", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_base = 32'h2000; in_base_idx = 4'd15; in_imm = 13'd4095; in_sub = 1; fire(); expect_out("R4 pc -4095 ok", 1, 32'h1001, 2'b00);
    dflt(); in_wide = 0; in_imm = 13'd4095; fire(); expect_out("R4 +4095 ok", 1, 32'hFFF, 2'b00);
    dflt(); in_wide = 0; in_imm = 13'd4096; fire(); expect_out("R4 +4096 bad", 0, 32'h0, 2'b00);
  endtask

  task automatic t_wide_shift();
    dflt(); in_use_reg = 1; in_off = 32'h8000_0001; in_shift_amt = 5'd4; fire(); expect_out("R5 lsl 4", 1, 32'h10, 2'b00);
    dflt(); in_use_reg = 1; in_base = 32'h100; in_off = 32'h8000_0001; in_shift_type = 2'b01; fire(); expect_out("R5 lsr 32", 1, 32'h100, 2'b00);
    dflt(); in_use_reg = 1; in_base = 32'h100; in_off = 32'h8000_0001; in_shift_type = 2'b10; fire(); expect_out("R5 asr 32", 1, 32'hFF, 2'b00);
    dflt(); in_use_reg = 1; in_off = 32'h8000_0000; in_shift_type = 2'b10; in_shift_amt = 5'd4; fire(); expect_out("R5 asr 4", 1, 32'hF800_0000, 2'b00);
    dflt(); in_use_reg = 1; in_off = 32'h8000_0001; in_shift_type = 2'b11; in_shift_amt = 5'd1; fire(); expect_out("R5 ror 1", 1, 32'hC000_0000, 2'b00);
    dflt(); in_use_reg = 1; in_off = 32'h8000_0001; in_shift_type = 2'b11; fire(); expect_out("R5 ror 0 bad", 0, 32'h0, 2'b00);
    dflt(); in_use_reg = 1; in_base = 32'h100; in_off = 32'h10; in_shift_amt = 5'd2; in_sub = 1; fire(); expect_out("R5 sub lsl 2", 1, 32'hC0, 2'b00);
  endtask

  task automatic t_compact_reg();
    dflt(); in_wide = 0; in_use_reg = 1; in_base = 32'h1000; in_off = 32'h10; in_shift_amt = 5'd3; fire(); expect_out("R6 lsl 3 ok", 1, 32'h1080, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_shift_amt = 5'd4; fire(); expect_out("R6 lsl 4 bad", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_shift_type = 2'b01; in_shift_amt = 5'd1; fire(); expect_out("R6 lsr bad", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_sub = 1; fire(); expect_out("R6 sub bad", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_base_idx = 4'd13; fire(); expect_out("R6 sp base bad", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_base_idx = 4'd15; fire(); expect_out("R6 pc base bad", 0, 32'h0, 2'b00);
  endtask

  task automatic t_off_pc();
    dflt(); in_use_reg = 1; in_off_idx = 4'd15; fire(); expect_out("R7 wide pc offset", 0, 32'h0, 2'b00);
    dflt(); in_wide = 0; in_use_reg = 1; in_off_idx = 4'd15; fire(); expect_out("R7 compact pc offset", 0, 32'h0, 2'b00);
  endtask

  task automatic t_kind();
    dflt(); in_kind = 2'b01; fire(); expect_out("R8 write intent kept", 1, 32'h0, 2'b01);
    dflt(); in_kind = 2'b01; in_mp_en = 0; fire(); expect_out("R8 write intent downgraded", 1, 32'h0, 2'b00);
    dflt(); in_kind = 2'b10; fire(); expect_out("R8 instruction", 1, 32'h0, 2'b10);
    dflt(); in_kind = 2'b11; fire(); expect_out("R9 kind 11 bad", 0, 32'h0, 2'b11);
  endtask

  task automatic t_overlap();
    dflt(); in_wide = 0; in_use_reg = 1; in_sub = 1; in_kind = 2'b01; in_mp_en = 0;
    fire(); expect_out("R9 illegal with downgrade", 0, 32'h0, 2'b00);
    dflt(); in_base = 32'h40; in_imm = 13'd4; fire(); expect_out("R1 back-to-back legal", 1, 32'h44, 2'b00);
    dflt(); in_imm = 13'd5000; fire(); expect_out("R1 back-to-back illegal", 0, 32'h0, 2'b00);
    dflt(); @(negedge clk); expect_idle("R1 idle after burst");
  endtask

  initial begin
    t_reset();
    t_imm_addr();
    t_wide_imm();
    t_compact_imm();
    t_wide_shift();
    t_compact_reg();
    t_off_pc();
    t_kind();
    t_overlap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule